// File: doc/BRIEF.md
# Four-Channel Double-Buffered DAC Code Register Front End

This block is the digital register front end of a four-channel, 8-bit voltage DAC. A host writes codes over one shared data bus. A two-bit channel address and an active-low write strobe steer each code into one of four input latches. A second active-low load strobe copies all four input latches into the output (DAC) latches in the same cycle, so every channel changes at once. The four output-latch codes leave the block as one flat vector. Each channel occupies its own byte, and a code N stands for N/256 of the reference level.

The host's strobes, address and data arrive with no relation to the system clock. They pass through a two-flop synchronizer, and each latch then updates on the clock. A low strobe level makes a latch transparent: it reloads every cycle. The last value sampled before the strobe rises is the one that is kept. If the load strobe is held low, the output latches stay transparent, and a write reaches the outputs without a separate load pulse. A parameter selects a single-buffered build in which the outputs track the input latches and the load strobe has no effect.

Top module: `quad_dac_frontend`

## Requirements
- R1: The address picks the channel: 0 selects channel A on code_o[7:0], 1 selects B on [15:8], 2 selects C on [23:16] and 3 selects D on [31:24]. A write changes only the addressed channel.
- R2: While wr_n is low, the addressed input latch follows data_i. After wr_n returns high, it keeps the last data sampled while wr_n was low.
- R3: While wr_n is high, no input latch changes, whatever addr_i and data_i do.
- R4: With the double-buffered build and ld_n high, writes do not change code_o. A low pulse on ld_n copies all four input latches to code_o in the same clock cycle.
- R5: While ld_n is held low, the output latches are transparent, and a write appears on code_o without a further load pulse.
- R6: When wr_n and ld_n go low together, the new data passes through to code_o.
- R7: After reset, every input latch and every output code is zero.
- R8: With the single-buffered build (DOUBLE_BUF=0), each channel of code_o follows its input latch, and ld_n has no effect.
- R9: A change on the inputs that is set up before clock edge k appears on code_o right after edge k+2, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_i | input | DW | Shared code bus |
| addr_i | input | AW | Channel select, 0..NCH-1 |
| wr_n_i | input | 1 | Active-low write strobe, asynchronous |
| ld_n_i | input | 1 | Active-low load strobe, asynchronous; ignored when DOUBLE_BUF=0 |
| code_o | output | NCH*DW | Output latch codes, channel i at bits [i*DW +: DW] |

## Verification
The bench builds two copies of the block side by side from the same stimulus: one with DOUBLE_BUF=1 and one with DOUBLE_BUF=0, both with four channels of eight bits. Comparing the two builds shows the input latches directly through the single-buffered copy, so writes that must be ignored, and the hold of the output latches, can be observed before any load pulse. Strobe overlap, a held-low load strobe and the exact cycle in which a code first appears are each driven in a directed scenario.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  // Lowest bit of channel ch in a flat code vector
  function automatic int unsigned lane_lsb(input int unsigned ch, input int unsigned dw);
    return ch * dw;
  endfunction

  // Effective output-latch load control: single-buffered builds keep it transparent
  function automatic logic eff_load_n(input logic ld_n, input bit double_buf);
    return double_buf ? ld_n : 1'b0;
  endfunction
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {STAGES{RST_VAL}};
    else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/qdac_in_bank.sv
module qdac_in_bank #(
  parameter int NCH = 4,
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_n,
  input  logic [AW-1:0]           addr,
  input  logic [DW-1:0]           data,
  output logic [NCH-1:0][DW-1:0]  in_q,
  output logic [NCH-1:0][DW-1:0]  in_next,
  output logic [NCH-1:0]          wr_sel
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign wr_sel[i]  = !wr_n && (addr == AW'(i));
    assign in_next[i] = wr_sel[i] ? data : in_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) in_q[i] <= '0;
      else        in_q[i] <= in_next[i];
    end
  end

  p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(wr_sel))
    else $error("R1: more than one channel selected");
  p_keep_idle_r3: assert property (@(posedge clk) disable iff (!rst_n) wr_n |=> $stable(in_q))
    else $error("R3: input latch moved with write strobe high");
  p_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |=> in_q[$past(addr)] == $past(data))
    else $error("R2: addressed latch did not follow the bus");
endmodule

// File: rtl/qdac_out_bank.sv
module qdac_out_bank
  import qdac_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW = 8,
  parameter bit DOUBLE_BUF = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld_n,
  input  logic [NCH-1:0][DW-1:0]  in_next,
  output logic [NCH-1:0][DW-1:0]  dac_q
);
  logic load_open_n;
  assign load_open_n = eff_load_n(ld_n, DOUBLE_BUF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            dac_q <= '0;
    else if (!load_open_n) dac_q <= in_next;
  end

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (DOUBLE_BUF && ld_n) |=> $stable(dac_q))
    else $error("R4: output latch moved with load strobe high");
endmodule

// File: rtl/quad_dac_frontend.sv
module quad_dac_frontend
  import qdac_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW = 8,
  parameter bit DOUBLE_BUF = 1'b1,
  parameter int SYNC_STAGES = 2,
  localparam int AW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int SW = 2 + AW + DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     data_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              wr_n_i,
  input  logic              ld_n_i,
  output logic [NCH*DW-1:0] code_o
);
  // Strobes idle high, bus and address idle zero
  localparam logic [SW-1:0] SYNC_RST = {2'b11, {(AW+DW){1'b0}}};

  logic [SW-1:0] sync_q;
  logic          s_wr_n, s_ld_n;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_data;

  qdac_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({wr_n_i, ld_n_i, addr_i, data_i}),
    .q(sync_q)
  );
  assign {s_wr_n, s_ld_n, s_addr, s_data} = sync_q;

  logic [NCH-1:0][DW-1:0] in_q, in_next, dac_q;
  logic [NCH-1:0]         wr_sel;

  qdac_in_bank #(.NCH(NCH), .DW(DW), .AW(AW)) u_in (
    .clk(clk), .rst_n(rst_n), .wr_n(s_wr_n), .addr(s_addr), .data(s_data),
    .in_q(in_q), .in_next(in_next), .wr_sel(wr_sel)
  );

  qdac_out_bank #(.NCH(NCH), .DW(DW), .DOUBLE_BUF(DOUBLE_BUF)) u_out (
    .clk(clk), .rst_n(rst_n), .ld_n(s_ld_n), .in_next(in_next), .dac_q(dac_q)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_pack
    assign code_o[lane_lsb(i, DW) +: DW] = dac_q[i];
  end

  p_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!s_ld_n && DOUBLE_BUF) |=> (dac_q == in_q))
    else $error("R5: transparent output latch lags input latch");
  p_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !DOUBLE_BUF |-> (dac_q == in_q))
    else $error("R8: single-buffered output differs from input latch");
endmodule

// File: tb/sim_quad_dac_frontend.sv
module sim_quad_dac_frontend;
  localparam int NCH = 4;
  localparam int DW = 8;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] data = '0;
  logic [AW-1:0] addr = '0;
  logic wr_n = 1'b1;
  logic ld_n = 1'b1;
  logic [NCH*DW-1:0] code_dbl, code_sgl;

  always #4 clk = ~clk;

  quad_dac_frontend #(.NCH(NCH), .DW(DW), .DOUBLE_BUF(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .data_i(data), .addr_i(addr),
    .wr_n_i(wr_n), .ld_n_i(ld_n), .code_o(code_dbl));
  quad_dac_frontend #(.NCH(NCH), .DW(DW), .DOUBLE_BUF(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .data_i(data), .addr_i(addr),
    .wr_n_i(wr_n), .ld_n_i(ld_n), .code_o(code_sgl));

  int total = 0;
  int bad = 0;
  logic [DW-1:0] ref_in [NCH];
  logic [DW-1:0] ref_dac [NCH];

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < NCH; i++) begin
      chk({req, " dbl"}, code_dbl[i*DW +: DW], ref_dac[i]);
      chk({req, " sgl"}, code_sgl[i*DW +: DW], ref_in[i]);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [AW-1:0] ch, input logic [DW-1:0] v);
    addr = ch; data = v; wr_n = 1'b0;
    wait_n(3);
    wr_n = 1'b1;
    wait_n(4);
    ref_in[ch] = v;
    if (!ld_n) ref_dac = ref_in;
  endtask

  task automatic do_load();
    ld_n = 1'b0;
    wait_n(2);
    ld_n = 1'b1;
    wait_n(4);
    ref_dac = ref_in;
  endtask

  task automatic t_reset_r7();
    check_all("R7 reset zero");
  endtask

  task automatic t_decode_r1();
    do_write(2'd0, 8'h11);
    do_write(2'd1, 8'h22);
    do_write(2'd2, 8'h33);
    do_write(2'd3, 8'hFF);
    check_all("R1 R4 R8 decode, no load yet");
  endtask

  task automatic t_load_r4();
    do_load();
    check_all("R4 load copies all");
  endtask

  task automatic t_ignore_r3();
    for (int k = 0; k < 6; k++) begin
      addr = AW'(k); data = 8'hA0 + DW'(k);
      wait_n(1);
    end
    wait_n(4);
    check_all("R3 idle bus before load");
    do_load();
    check_all("R3 idle bus after load");
  endtask

  task automatic t_transparent_r2();
    addr = 2'd2; wr_n = 1'b0;
    for (int k = 0; k < 3; k++) begin
      data = 8'h40 + DW'(k);
      wait_n(4);
      chk("R2 follows while low", code_sgl[2*DW +: DW], 8'h40 + DW'(k));
    end
    wr_n = 1'b1;
    wait_n(4);
    data = 8'h99;
    wait_n(4);
    ref_in[2] = 8'h42;
    chk("R2 holds after rise", code_sgl[2*DW +: DW], 8'h42);
    check_all("R2 other lanes");
  endtask

  task automatic t_ldheld_r5();
    ld_n = 1'b0;
    wait_n(4);
    ref_dac = ref_in;
    do_write(2'd1, 8'h5A);
    check_all("R5 held load transparent");
    do_write(2'd3, 8'h00);
    check_all("R5 second write");
    ld_n = 1'b1;
    wait_n(4);
  endtask

  task automatic t_both_r6();
    addr = 2'd0; data = 8'hC3; wr_n = 1'b0; ld_n = 1'b0;
    wait_n(3);
    wr_n = 1'b1; ld_n = 1'b1;
    wait_n(4);
    ref_in[0] = 8'hC3;
    ref_dac = ref_in;
    check_all("R6 both strobes pass");
  endtask

  task automatic t_latency_r9();
    ld_n = 1'b0;
    wait_n(4);
    addr = 2'd3; data = 8'h7E; wr_n = 1'b0;
    wait_n(2);
    chk("R9 not yet sgl", code_sgl[3*DW +: DW], ref_in[3]);
    chk("R9 not yet dbl", code_dbl[3*DW +: DW], ref_dac[3]);
    wait_n(1);
    chk("R9 appears sgl", code_sgl[3*DW +: DW], 8'h7E);
    chk("R9 appears dbl", code_dbl[3*DW +: DW], 8'h7E);
    wr_n = 1'b1; ld_n = 1'b1;
    wait_n(4);
    ref_in[3] = 8'h7E;
    ref_dac = ref_in;
    check_all("R9 settled");
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) begin
      ref_in[i] = '0;
      ref_dac[i] = '0;
    end
    wait_n(3);
    t_reset_r7();
    rst_n = 1'b1;
    wait_n(3);
    t_reset_r7();
    t_decode_r1();
    t_load_r4();
    t_ignore_r3();
    t_transparent_r2();
    do_load();
    check_all("R4 reload");
    t_ldheld_r5();
    t_both_r6();
    t_latency_r9();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule